// File: doc/BRIEF.md
# Processor Bus Ownership Controller

This block sits between a host and an attached 8-bit processor of the Z80 class. It owns the processor's active-low reset and bus-request lines, watches the active-low bus-acknowledge line, and switches the host's address drivers on or off. It always knows two things: whether the processor is held in reset or is running, and whether the host currently holds the processor's buses. Those two facts form a 2-bit state.

The host sends six one-hot commands: reset, request, release, run, restart and single-step. Some commands finish on the clock edge that accepts them. Others start a wait for bus acknowledge, a timed reset pulse or a short bus-request gap, and `busy_o` stays high until that work ends. Bus acknowledge passes through a synchronizer before the sequencer sees it. Acquiring the bus from the reset state lets the processor out of reset so that it can grant the bus. A run command issued while the host holds the bus pulses reset and keeps ownership. A single step opens a brief gap in bus request so that the processor can advance by one machine cycle.

Top module: `zbus_owner_ctrl`

## Requirements
- R1: After `rst`, the controller is in state 0 with reset low, bus request high, the address drivers off and busy low. A reset command (`cmd_i` bit 0) returns any state to these values.
- R2: A request command (bit 1) in state 0 drives bus request low and reset high. Busy stays high and the address drivers stay off until the synchronized acknowledge is low. The drivers then turn on and the state becomes 1.
- R3: A request in state 2 drives bus request low and keeps reset high. After acknowledge, the address drivers turn on and the state becomes 3.
- R4: A release command (bit 2) takes effect on the accepting edge. In state 1 it turns the drivers off, drives reset low, raises bus request and enters state 0. In state 3 it does the same except that reset stays high, and it enters state 2.
- R5: A run command (bit 3) in state 0 raises reset and enters state 2 on the accepting edge. In state 1 it turns the drivers off and holds reset low for exactly PULSE_CYCLES cycles. It then raises reset, turns the drivers back on and enters state 3.
- R6: A restart command (bit 4) in state 2 or state 3 holds reset low for exactly PULSE_CYCLES cycles and leaves the state and the drivers as they were.
- R7: A step command (bit 5) in state 3 turns the drivers off and raises bus request for exactly GAP_CYCLES cycles. It then lowers bus request, waits for acknowledge, turns the drivers back on and stays in state 3.
- R8: A command that has no action in the current state changes no output.
- R9: A command word with more than one bit set is ignored.
- R10: While busy is high, every command except reset is ignored. A reset command is accepted while busy and abandons the work in progress.
- R11: The address drivers are on only while bus request is low. In idle states 1 and 3 the drivers are always on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 6 | One-hot command: 0 reset, 1 request, 2 release, 3 run, 4 restart, 5 step |
| busack_n_i | input | 1 | Processor bus acknowledge, active low, asynchronous |
| reset_n_o | output | 1 | Processor reset, active low |
| busreq_n_o | output | 1 | Processor bus request, active low |
| addr_oe_o | output | 1 | Host address driver enable |
| state_o | output | 2 | 0 halted, 1 halted and owned, 2 running, 3 running and owned |
| busy_o | output | 1 | A timed action or an acknowledge wait is in progress |

## Verification
The assertions check the relations between outputs on every cycle. Drivers are on only while bus request is asserted. Each idle state shows its own fixed line levels. Reset and bus request may leave those levels in states 2 and 3 only while busy is high. Only the bench scenarios can show the transitions themselves: that each command lands in the correct next state, that the reset pulse and the request gap last exactly their set number of cycles, that illegal, multi-bit and mid-busy commands leave the outputs untouched, and that a reset command frees a controller stuck waiting for an acknowledge that never arrives.

// File: rtl/zbus_pkg.sv
package zbus_pkg;

  localparam int CMD_W = 6;

  // one-hot command bit positions
  localparam int CB_RESET   = 0;
  localparam int CB_REQUEST = 1;
  localparam int CB_RELEASE = 2;
  localparam int CB_RUN     = 3;
  localparam int CB_RESTART = 4;
  localparam int CB_STEP    = 5;

  typedef enum logic [1:0] {
    ZS_HALTED     = 2'd0,
    ZS_HALTED_OWN = 2'd1,
    ZS_LIVE       = 2'd2,
    ZS_LIVE_OWN   = 2'd3
  } zstate_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RESET,
    OP_REQUEST,
    OP_RELEASE,
    OP_RUN,
    OP_RESTART,
    OP_STEP
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ACK,
    PH_PULSE,
    PH_GAP
  } phase_e;

endpackage

// File: rtl/zbus_sync.sv
module zbus_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  // chain of flops; STAGES must be at least 2
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RESET_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/zbus_timer.sv
module zbus_timer #(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] len_m1_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= len_m1_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/zbus_cmd_decode.sv
module zbus_cmd_decode
  import zbus_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             busy_i,
  output op_e              op_o
);
  always_comb begin
    op_o = OP_NONE;
    if ($onehot(cmd_i)) begin
      if (cmd_i[CB_RESET])        op_o = OP_RESET;
      else if (!busy_i) begin
        if (cmd_i[CB_REQUEST])      op_o = OP_REQUEST;
        else if (cmd_i[CB_RELEASE]) op_o = OP_RELEASE;
        else if (cmd_i[CB_RUN])     op_o = OP_RUN;
        else if (cmd_i[CB_RESTART]) op_o = OP_RESTART;
        else if (cmd_i[CB_STEP])    op_o = OP_STEP;
      end
    end
  end
endmodule

// File: rtl/zbus_seq.sv
module zbus_seq
  import zbus_pkg::*;
#(
  parameter int PULSE_CYCLES = 1250,
  parameter int GAP_CYCLES   = 2,
  parameter int TW           = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  op_e           op_i,
  input  logic          ack_low_i,
  input  logic          tzero_i,
  output logic          t_load_o,
  output logic [TW-1:0] t_len_o,
  output logic          reset_n_o,
  output logic          busreq_n_o,
  output logic          addr_oe_o,
  output zstate_e       state_o,
  output logic          busy_o
);
  localparam logic [TW-1:0] PULSE_M1 = TW'(PULSE_CYCLES - 1);
  localparam logic [TW-1:0] GAP_M1   = TW'(GAP_CYCLES - 1);

  zstate_e state_q, tgt_q;
  phase_e  phase_q;
  logic    rn_q, br_q, oe_q, reen_q;

  // timer load on the accepting edge of a timed command
  always_comb begin
    t_load_o = 1'b0;
    t_len_o  = PULSE_M1;
    if (phase_q == PH_IDLE) begin
      unique case (op_i)
        OP_RUN:     t_load_o = (state_q == ZS_HALTED_OWN);
        OP_RESTART: t_load_o = state_q[1];
        OP_STEP: begin
          t_load_o = (state_q == ZS_LIVE_OWN);
          t_len_o  = GAP_M1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || op_i == OP_RESET) begin
      state_q <= ZS_HALTED;
      tgt_q   <= ZS_HALTED;
      phase_q <= PH_IDLE;
      rn_q    <= 1'b0;
      br_q    <= 1'b1;
      oe_q    <= 1'b0;
      reen_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          unique case (op_i)
            OP_REQUEST: begin
              if (state_q == ZS_HALTED) begin
                br_q    <= 1'b0;
                rn_q    <= 1'b1;
                tgt_q   <= ZS_HALTED_OWN;
                phase_q <= PH_ACK;
              end else if (state_q == ZS_LIVE) begin
                br_q    <= 1'b0;
                tgt_q   <= ZS_LIVE_OWN;
                phase_q <= PH_ACK;
              end
            end
            OP_RELEASE: begin
              if (state_q == ZS_HALTED_OWN) begin
                oe_q    <= 1'b0;
                rn_q    <= 1'b0;
                br_q    <= 1'b1;
                state_q <= ZS_HALTED;
              end else if (state_q == ZS_LIVE_OWN) begin
                oe_q    <= 1'b0;
                br_q    <= 1'b1;
                state_q <= ZS_LIVE;
              end
            end
            OP_RUN: begin
              if (state_q == ZS_HALTED) begin
                rn_q    <= 1'b1;
                state_q <= ZS_LIVE;
              end else if (state_q == ZS_HALTED_OWN) begin
                oe_q    <= 1'b0;
                rn_q    <= 1'b0;
                reen_q  <= 1'b1;
                tgt_q   <= ZS_LIVE_OWN;
                phase_q <= PH_PULSE;
              end
            end
            OP_RESTART: begin
              if (state_q[1]) begin
                rn_q    <= 1'b0;
                reen_q  <= 1'b0;
                tgt_q   <= state_q;
                phase_q <= PH_PULSE;
              end
            end
            OP_STEP: begin
              if (state_q == ZS_LIVE_OWN) begin
                oe_q    <= 1'b0;
                br_q    <= 1'b1;
                tgt_q   <= ZS_LIVE_OWN;
                phase_q <= PH_GAP;
              end
            end
            default: ;
          endcase
        end
        PH_ACK: begin
          if (ack_low_i) begin
            oe_q    <= 1'b1;
            state_q <= tgt_q;
            phase_q <= PH_IDLE;
          end
        end
        PH_PULSE: begin
          if (tzero_i) begin
            rn_q    <= 1'b1;
            state_q <= tgt_q;
            phase_q <= PH_IDLE;
            if (reen_q) oe_q <= 1'b1;
          end
        end
        PH_GAP: begin
          if (tzero_i) begin
            br_q    <= 1'b0;
            phase_q <= PH_ACK;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign reset_n_o  = rn_q;
  assign busreq_n_o = br_q;
  assign addr_oe_o  = oe_q;
  assign state_o    = state_q;
  assign busy_o     = (phase_q != PH_IDLE);
endmodule

// File: rtl/zbus_owner_ctrl.sv
module zbus_owner_ctrl
  import zbus_pkg::*;
#(
  parameter int PULSE_CYCLES = 1250,
  parameter int GAP_CYCLES   = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             busack_n_i,
  output logic             reset_n_o,
  output logic             busreq_n_o,
  output logic             addr_oe_o,
  output logic [1:0]       state_o,
  output logic             busy_o
);
  localparam int TMAX = (PULSE_CYCLES > GAP_CYCLES) ? PULSE_CYCLES : GAP_CYCLES;
  localparam int TW   = (TMAX < 2) ? 1 : $clog2(TMAX + 1);

  op_e           op;
  logic          ack_n_s;
  logic          t_load, t_zero;
  logic [TW-1:0] t_len;
  zstate_e       st;

  zbus_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (busack_n_i),
    .q_o (ack_n_s)
  );

  zbus_cmd_decode u_dec (
    .cmd_i  (cmd_i),
    .busy_i (busy_o),
    .op_o   (op)
  );

  zbus_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_i   (t_load),
    .len_m1_i (t_len),
    .zero_o   (t_zero)
  );

  zbus_seq #(.PULSE_CYCLES(PULSE_CYCLES), .GAP_CYCLES(GAP_CYCLES), .TW(TW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op),
    .ack_low_i  (!ack_n_s),
    .tzero_i    (t_zero),
    .t_load_o   (t_load),
    .t_len_o    (t_len),
    .reset_n_o  (reset_n_o),
    .busreq_n_o (busreq_n_o),
    .addr_oe_o  (addr_oe_o),
    .state_o    (st),
    .busy_o     (busy_o)
  );

  assign state_o = st;
endmodule

// File: rtl/zbus_owner_chk.sv
module zbus_owner_chk (
  input logic       clk,
  input logic       rst,
  input logic       reset_n_o,
  input logic       busreq_n_o,
  input logic       addr_oe_o,
  input logic [1:0] state_o,
  input logic       busy_o
);
  AST_OE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    addr_oe_o |-> !busreq_n_o); // R11

  AST_OWNED_IDLE_OE: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && state_o[0]) |-> addr_oe_o); // R11

  AST_HALTED_LINES: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && state_o == 2'd0) |-> (!reset_n_o && busreq_n_o && !addr_oe_o)); // R1

  AST_LIVE_LINES: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && state_o == 2'd2) |-> (reset_n_o && busreq_n_o && !addr_oe_o)); // R4

  AST_LIVE_RESET_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!reset_n_o && state_o[1]) |-> busy_o); // R6

  AST_STEP_GAP_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busreq_n_o && state_o == 2'd3) |-> busy_o); // R7

  AST_RELEASE_DROPS_OE: assert property (@(posedge clk) disable iff (rst)
    ($fell(state_o[0]) && !busy_o) |-> (busreq_n_o && !addr_oe_o)); // R4
endmodule

bind zbus_owner_ctrl zbus_owner_chk u_chk (.*);

// File: tb/tb_zbus_owner_ctrl.sv
module tb_zbus_owner_ctrl;
  localparam int PULSE = 1250;
  localparam int GAP   = 2;

  localparam logic [5:0] C_RESET   = 6'b000001;
  localparam logic [5:0] C_REQUEST = 6'b000010;
  localparam logic [5:0] C_RELEASE = 6'b000100;
  localparam logic [5:0] C_RUN     = 6'b001000;
  localparam logic [5:0] C_RESTART = 6'b010000;
  localparam logic [5:0] C_STEP    = 6'b100000;

  typedef struct {
    logic [1:0] st;
    logic       rn;
    logic       br;
    logic       oe;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cmd = '0;
  logic       busack_n;
  logic       hold_ack = 1'b0;
  logic       reset_n_o, busreq_n_o, addr_oe_o, busy_o;
  logic [1:0] state_o;

  int   checks = 0;
  int   errors = 0;
  bit   pending = 1'b0;
  bit   finished = 1'b0;
  exp_t q[$];

  logic [2:0] apipe;
  int rl_run = 0, rl_last = 0, bh_run = 0, bh_last = 0;

  always #4 clk = ~clk;

  zbus_owner_ctrl #(.PULSE_CYCLES(PULSE), .GAP_CYCLES(GAP)) dut (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (cmd),
    .busack_n_i (busack_n),
    .reset_n_o  (reset_n_o),
    .busreq_n_o (busreq_n_o),
    .addr_oe_o  (addr_oe_o),
    .state_o    (state_o),
    .busy_o     (busy_o)
  );

  // processor model: acknowledge follows bus request after three clocks
  always @(posedge clk) begin
    if (rst) apipe <= '1;
    else     apipe <= {apipe[1:0], busreq_n_o};
  end
  assign busack_n = hold_ack ? 1'b1 : apipe[2];

  // run-length trackers for reset low and bus request high
  always @(negedge clk) begin
    if (!reset_n_o) rl_run <= rl_run + 1;
    else begin
      if (rl_run != 0) rl_last <= rl_run;
      rl_run <= 0;
    end
    if (busreq_n_o) bh_run <= bh_run + 1;
    else begin
      if (bh_run != 0) bh_last <= bh_run;
      bh_run <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops one expected item once the command has settled
  always @(negedge clk) begin
    if (pending && !busy_o && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({state_o, reset_n_o, busreq_n_o, addr_oe_o} == {e.st, e.rn, e.br, e.oe},
          e.tag, int'({state_o, reset_n_o, busreq_n_o, addr_oe_o}),
          int'({e.st, e.rn, e.br, e.oe}));
      pending = 1'b0;
    end
  end

  function automatic exp_t mk(input logic [1:0] st, input logic rn, input logic br,
                              input logic oe, input string tag);
    exp_t e;
    e.st = st; e.rn = rn; e.br = br; e.oe = oe; e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [5:0] c, input exp_t e);
    q.push_back(e);
    @(negedge clk) cmd = c;
    @(negedge clk) cmd = '0;
    pending = 1'b1;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    chk({state_o, reset_n_o, busreq_n_o, addr_oe_o, busy_o} == 6'b000100, "R1 after rst",
        int'({state_o, reset_n_o, busreq_n_o, addr_oe_o, busy_o}), 6'b000100);

    // R8 commands with no action in state 0
    send(C_RELEASE, mk(2'd0, 0, 1, 0, "R8 release in state 0"));
    send(C_STEP,    mk(2'd0, 0, 1, 0, "R8 step in state 0"));
    send(C_RESTART, mk(2'd0, 0, 1, 0, "R8 restart in state 0"));
    // R9 two bits set
    send(C_REQUEST | C_RUN, mk(2'd0, 0, 1, 0, "R9 multi-bit command"));

    // R2 acquire from halted
    send(C_REQUEST, mk(2'd1, 1, 0, 1, "R2 request in state 0"));
    send(C_REQUEST, mk(2'd1, 1, 0, 1, "R8 request in state 1"));
    // R4 release from state 1
    send(C_RELEASE, mk(2'd0, 0, 1, 0, "R4 release in state 1"));

    // R5 run while owned
    send(C_REQUEST, mk(2'd1, 1, 0, 1, "R2 second request"));
    send(C_RUN,     mk(2'd3, 1, 0, 1, "R5 run in state 1"));
    chk(rl_last == PULSE, "R5 pulse width", rl_last, PULSE);

    // R4 release from state 3
    send(C_RELEASE, mk(2'd2, 1, 1, 0, "R4 release in state 3"));

    // R6 restart in state 2
    send(C_RESTART, mk(2'd2, 1, 1, 0, "R6 restart in state 2"));
    chk(rl_last == PULSE, "R6 pulse width state 2", rl_last, PULSE);

    // R10 request during a pulse is dropped
    q.push_back(mk(2'd2, 1, 1, 0, "R10 request while busy"));
    @(negedge clk) cmd = C_RESTART;
    @(negedge clk) cmd = C_REQUEST;
    @(negedge clk) cmd = '0;
    pending = 1'b1;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);

    send(C_STEP, mk(2'd2, 1, 1, 0, "R8 step in state 2"));

    // R3 acquire while running
    send(C_REQUEST, mk(2'd3, 1, 0, 1, "R3 request in state 2"));

    // R6 restart in state 3 keeps ownership
    send(C_RESTART, mk(2'd3, 1, 0, 1, "R6 restart in state 3"));
    chk(rl_last == PULSE, "R6 pulse width state 3", rl_last, PULSE);

    // R7 single step
    send(C_STEP, mk(2'd3, 1, 0, 1, "R7 step in state 3"));
    chk(bh_last == GAP, "R7 gap width", bh_last, GAP);

    send(C_RUN, mk(2'd3, 1, 0, 1, "R8 run in state 3"));
    send(C_RELEASE, mk(2'd2, 1, 1, 0, "R4 release back to running"));

    // R1 reset command from state 2
    send(C_RESET, mk(2'd0, 0, 1, 0, "R1 reset command"));

    // R5 run from halted
    send(C_RUN, mk(2'd2, 1, 1, 0, "R5 run in state 0"));

    // R10 acknowledge withheld: stays busy, reset command aborts
    hold_ack = 1'b1;
    @(negedge clk) cmd = C_REQUEST;
    @(negedge clk) cmd = '0;
    repeat (20) @(negedge clk);
    chk(busy_o == 1'b1, "R2 busy while waiting for ack", int'(busy_o), 1);
    chk(addr_oe_o == 1'b0 && state_o == 2'd2, "R2 drivers off before ack",
        int'({state_o, addr_oe_o}), 3'b100);
    send(C_RESET, mk(2'd0, 0, 1, 0, "R10 reset aborts wait"));
    chk(busy_o == 1'b0, "R10 busy cleared by reset", int'(busy_o), 0);
    hold_ack = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule